// File: doc/BRIEF.md
# Load-Store Disambiguation Buffer

This block keeps the memory operations of an out-of-order core in program order so that loads may run before older stores have computed their addresses. Each load or store takes a slot when it issues, before its address exists. Later, and in any order, the slot receives its word address, and a store slot may also receive its data. Every ordering check runs when an address arrives.

When a load's address arrives, the buffer looks at the older stores with the same word address. The youngest such store supplies its data if the data is already present. If the data is not present, the buffer returns the producer tag that the store recorded when it was allocated. If no older store matches, the load is told to go to memory. When a store's address arrives, the buffer looks for younger loads that already hold the same address. Such a load read stale data. The buffer flags the oldest such load for a flush and drops that load and every younger slot by moving the tail pointer back to the load's index.

The buffer is a circular queue whose depth is a power of two. Slots leave from the head in program order on retire. The load response and the flush request are registered and appear on the cycle after the address arrives.

Top module: `mem_order_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `lrsp_valid` and `flush_valid` are 0.
- R2: An accepted allocation takes the slot shown on `alloc_idx`. Successive allocations get consecutive indices, which wrap modulo DEPTH.
- R3: When DEPTH slots are occupied, `alloc_ready` is 0 and a requested allocation is ignored. One retire makes `alloc_ready` 1 again, and the next allocation takes the index the ignored request would have taken.
- R4: Each retire frees the oldest slot. A retire on an empty buffer is ignored.
- R5: A resolving load with no older, address-known store at the same word address produces `lrsp_kind` = 0 (go to memory) on the next cycle. Younger stores, retired stores and stores at other addresses do not count as matches.
- R6: A resolving load whose selected store holds data produces `lrsp_kind` = 1 with that data on `lrsp_data`.
- R7: A resolving load whose selected store has no data yet produces `lrsp_kind` = 2 with the store's producer tag on `lrsp_tag`.
- R8: When several older stores match, the youngest of them is selected.
- R9: Store data that arrives in the same cycle as the load's address, for the selected store, is forwarded as `lrsp_kind` = 1 with the new value.
- R10: A resolving store that matches younger loads which already hold addresses raises `flush_valid` on the next cycle, with `flush_idx` set to the oldest such load. The tail moves back to that index, so the next allocation receives it.
- R11: A resolving store that matches only older loads raises no flush.
- R12: In a cycle where a resolving store detects a violation, `alloc_ready` is 0 and no allocation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot for a new memory operation |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_tag | input | TAG_W | Producer tag of the store's data source |
| alloc_ready | output | 1 | An allocation can be accepted this cycle |
| alloc_idx | output | IDX_W | Slot index the next allocation receives |
| res_valid | input | 1 | An address is arriving for a slot |
| res_idx | input | IDX_W | Slot that receives the address |
| res_addr | input | ADDR_W | Word address |
| sdata_valid | input | 1 | Store data is arriving |
| sdata_idx | input | IDX_W | Store slot that receives the data |
| sdata_value | input | DATA_W | Store data value |
| retire_valid | input | 1 | Retire the oldest slot |
| lrsp_valid | output | 1 | Load response valid (one cycle) |
| lrsp_idx | output | IDX_W | Load slot the response is for |
| lrsp_kind | output | 2 | 0 go to memory, 1 forwarded data, 2 producer tag |
| lrsp_data | output | DATA_W | Forwarded data, 0 otherwise |
| lrsp_tag | output | TAG_W | Producer tag, 0 otherwise |
| flush_valid | output | 1 | Ordering violation flush request (one cycle) |
| flush_idx | output | IDX_W | Misspeculated load slot; this slot and all younger slots are dropped |

## Verification
Two pairs of functions can meet in one cycle. In the first, a load resolves while the store it selects receives its data. The bench drives both ports on the same edge and expects a forwarded value equal to the new data, not the producer tag. In the second, a store resolves into a violation while an allocation is requested. The bench samples `alloc_ready` low before the edge and then expects the next allocation to receive the flushed load's index, which shows that the refused request did not advance the tail.

// File: rtl/mob_pkg.sv
package mob_pkg;

  typedef enum logic [1:0] {
    RSP_MEM = 2'd0,
    RSP_FWD = 2'd1,
    RSP_TAG = 2'd2
  } rsp_kind_e;

  // Response class from the search outcome.
  function automatic rsp_kind_e pick_kind(input logic hit, input logic data_ok);
    if (!hit)        return RSP_MEM;
    else if (data_ok) return RSP_FWD;
    else             return RSP_TAG;
  endfunction

endpackage

// File: rtl/mob_slots.sv
module mob_slots #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_at,
  input  logic              alloc_store,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              addr_we,
  input  logic [IDX_W-1:0]  addr_at,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              data_we,
  input  logic [IDX_W-1:0]  data_at,
  input  logic [DATA_W-1:0] data_val,
  input  logic [DEPTH-1:0]  kill,
  output logic              ent_valid [DEPTH],
  output logic              ent_store [DEPTH],
  output logic              ent_aok   [DEPTH],
  output logic [ADDR_W-1:0] ent_addr  [DEPTH],
  output logic              ent_dok   [DEPTH],
  output logic [DATA_W-1:0] ent_data  [DEPTH],
  output logic [TAG_W-1:0]  ent_tag   [DEPTH]
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_valid[i] <= 1'b0;
        ent_store[i] <= 1'b0;
        ent_aok[i]   <= 1'b0;
        ent_addr[i]  <= '0;
        ent_dok[i]   <= 1'b0;
        ent_data[i]  <= '0;
        ent_tag[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i]) ent_valid[i] <= 1'b0;
      end
      if (addr_we) begin
        ent_addr[addr_at] <= addr_val;
        ent_aok[addr_at]  <= 1'b1;
      end
      if (data_we) begin
        ent_data[data_at] <= data_val;
        ent_dok[data_at]  <= 1'b1;
      end
      if (alloc_we) begin
        ent_valid[alloc_at] <= 1'b1;
        ent_store[alloc_at] <= alloc_store;
        ent_tag[alloc_at]   <= alloc_tag;
        ent_aok[alloc_at]   <= 1'b0;
        ent_dok[alloc_at]   <= 1'b0;
      end
    end
  end

  // R2: allocation only lands on a free slot
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> !ent_valid[alloc_at]);

endmodule

// File: rtl/mob_fwd_search.sv
module mob_fwd_search #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              ent_valid [DEPTH],
  input  logic              ent_store [DEPTH],
  input  logic              ent_aok   [DEPTH],
  input  logic [ADDR_W-1:0] ent_addr  [DEPTH],
  input  logic              ent_dok   [DEPTH],
  input  logic [DATA_W-1:0] ent_data  [DEPTH],
  input  logic [TAG_W-1:0]  ent_tag   [DEPTH],
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              byp_valid,
  input  logic [IDX_W-1:0]  byp_idx,
  input  logic [DATA_W-1:0] byp_data,
  output logic              hit,
  output logic              hit_dok,
  output logic [DATA_W-1:0] hit_data,
  output logic [TAG_W-1:0]  hit_tag
);

  logic [IDX_W-1:0] ring_idx [DEPTH];
  logic [IDX_W-1:0] ld_age;
  logic [IDX_W-1:0] sel;
  logic             byp_hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ring
    assign ring_idx[k] = head_idx + IDX_W'(k);
  end

  assign ld_age = ld_idx - head_idx;

  // Walk oldest to youngest among slots older than the load; the last match wins.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (IDX_W'(k) < ld_age && ent_valid[ring_idx[k]] && ent_store[ring_idx[k]] &&
          ent_aok[ring_idx[k]] && ent_addr[ring_idx[k]] == ld_addr) begin
        hit = 1'b1;
        sel = ring_idx[k];
      end
    end
  end

  assign byp_hit  = hit && byp_valid && byp_idx == sel;
  assign hit_dok  = byp_hit || ent_dok[sel];
  assign hit_data = byp_hit ? byp_data : ent_data[sel];
  assign hit_tag  = ent_tag[sel];

endmodule

// File: rtl/mob_viol_search.sv
module mob_viol_search #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              ent_valid [DEPTH],
  input  logic              ent_store [DEPTH],
  input  logic              ent_aok   [DEPTH],
  input  logic [ADDR_W-1:0] ent_addr  [DEPTH],
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              viol,
  output logic [IDX_W-1:0]  victim
);

  logic [IDX_W-1:0] ring_idx [DEPTH];
  logic [IDX_W-1:0] st_age;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ring
    assign ring_idx[k] = head_idx + IDX_W'(k);
  end

  assign st_age = st_idx - head_idx;

  // Walk youngest to oldest among younger loads; the last match is the oldest.
  always_comb begin
    viol   = 1'b0;
    victim = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (IDX_W'(k) > st_age && ent_valid[ring_idx[k]] && !ent_store[ring_idx[k]] &&
          ent_aok[ring_idx[k]] && ent_addr[ring_idx[k]] == st_addr) begin
        viol   = 1'b1;
        victim = ring_idx[k];
      end
    end
  end

endmodule

// File: rtl/mem_order_buf.sv
module mem_order_buf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              res_valid,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              sdata_valid,
  input  logic [IDX_W-1:0]  sdata_idx,
  input  logic [DATA_W-1:0] sdata_value,
  input  logic              retire_valid,
  output logic              lrsp_valid,
  output logic [IDX_W-1:0]  lrsp_idx,
  output logic [1:0]        lrsp_kind,
  output logic [DATA_W-1:0] lrsp_data,
  output logic [TAG_W-1:0]  lrsp_tag,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_idx
);
  import mob_pkg::*;

  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, tail_q;
  logic [PTR_W-1:0] occ;
  logic [IDX_W-1:0] head_idx;

  logic              ent_valid [DEPTH];
  logic              ent_store [DEPTH];
  logic              ent_aok   [DEPTH];
  logic [ADDR_W-1:0] ent_addr  [DEPTH];
  logic              ent_dok   [DEPTH];
  logic [DATA_W-1:0] ent_data  [DEPTH];
  logic [TAG_W-1:0]  ent_tag   [DEPTH];

  // Named internal events
  logic             full, empty;
  logic             res_load, res_store;
  logic             alloc_fire, retire_fire, viol_now;
  logic             viol_hit;
  logic [IDX_W-1:0] victim_idx, victim_age;
  logic             fwd_hit, fwd_dok;
  logic [DATA_W-1:0] fwd_data;
  logic [TAG_W-1:0] fwd_tag;
  logic [DEPTH-1:0] kill;
  rsp_kind_e        kind_now;

  assign occ      = tail_q - head_q;
  assign head_idx = head_q[IDX_W-1:0];
  assign full     = occ == PTR_W'(DEPTH);
  assign empty    = occ == '0;

  assign res_load  = res_valid && ent_valid[res_idx] && !ent_store[res_idx];
  assign res_store = res_valid && ent_valid[res_idx] &&  ent_store[res_idx];
  assign viol_now  = res_store && viol_hit;

  assign alloc_ready = !full && !viol_now;
  assign alloc_idx   = tail_q[IDX_W-1:0];
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_valid && !empty;
  assign victim_age  = victim_idx - head_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    assign kill[i] = (retire_fire && head_idx == IDX_W'(i)) ||
                     (viol_now && (IDX_W'(i) - head_idx) >= victim_age);
  end

  mob_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(alloc_fire), .alloc_at(alloc_idx), .alloc_store(alloc_is_store), .alloc_tag(alloc_tag),
    .addr_we(res_valid), .addr_at(res_idx), .addr_val(res_addr),
    .data_we(sdata_valid), .data_at(sdata_idx), .data_val(sdata_value),
    .kill(kill),
    .ent_valid(ent_valid), .ent_store(ent_store), .ent_aok(ent_aok), .ent_addr(ent_addr),
    .ent_dok(ent_dok), .ent_data(ent_data), .ent_tag(ent_tag)
  );

  mob_fwd_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_fwd (
    .ent_valid(ent_valid), .ent_store(ent_store), .ent_aok(ent_aok), .ent_addr(ent_addr),
    .ent_dok(ent_dok), .ent_data(ent_data), .ent_tag(ent_tag),
    .head_idx(head_idx), .ld_idx(res_idx), .ld_addr(res_addr),
    .byp_valid(sdata_valid), .byp_idx(sdata_idx), .byp_data(sdata_value),
    .hit(fwd_hit), .hit_dok(fwd_dok), .hit_data(fwd_data), .hit_tag(fwd_tag)
  );

  mob_viol_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_viol (
    .ent_valid(ent_valid), .ent_store(ent_store), .ent_aok(ent_aok), .ent_addr(ent_addr),
    .head_idx(head_idx), .st_idx(res_idx), .st_addr(res_addr),
    .viol(viol_hit), .victim(victim_idx)
  );

  assign kind_now = pick_kind(fwd_hit, fwd_dok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      lrsp_valid  <= 1'b0;
      lrsp_idx    <= '0;
      lrsp_kind   <= RSP_MEM;
      lrsp_data   <= '0;
      lrsp_tag    <= '0;
      flush_valid <= 1'b0;
      flush_idx   <= '0;
    end else begin
      if (retire_fire) head_q <= head_q + PTR_W'(1);
      if (viol_now)        tail_q <= head_q + {1'b0, victim_age};
      else if (alloc_fire) tail_q <= tail_q + PTR_W'(1);

      lrsp_valid <= res_load;
      lrsp_idx   <= res_idx;
      lrsp_kind  <= kind_now;
      lrsp_data  <= (kind_now == RSP_FWD) ? fwd_data : '0;
      lrsp_tag   <= (kind_now == RSP_TAG) ? fwd_tag  : '0;

      flush_valid <= viol_now;
      flush_idx   <= victim_idx;
    end
  end

  // R3: occupancy never exceeds the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH));

  // R10: a flush request coincides with the tail parked on the flushed load
  p_flush_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> tail_q[IDX_W-1:0] == flush_idx);

  // R5: every resolving load gets a response on the next cycle
  p_load_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> lrsp_valid);

  // R6: response class is one of the three legal codes
  p_kind_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lrsp_valid |-> lrsp_kind != 2'b11);

  // R4: a retire on an empty buffer leaves the head unchanged
  p_empty_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && empty) |=> head_q == $past(head_q));

endmodule

// File: tb/mem_order_buf_tb.sv
`timescale 1ns/1ps
module mem_order_buf_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_is_store;
  logic [5:0]  alloc_tag;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        res_valid;
  logic [2:0]  res_idx;
  logic [15:0] res_addr;
  logic        sdata_valid;
  logic [2:0]  sdata_idx;
  logic [31:0] sdata_value;
  logic        retire_valid;
  logic        lrsp_valid;
  logic [2:0]  lrsp_idx;
  logic [1:0]  lrsp_kind;
  logic [31:0] lrsp_data;
  logic [5:0]  lrsp_tag;
  logic        flush_valid;
  logic [2:0]  flush_idx;

  always #2 clk = ~clk;

  mem_order_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store), .alloc_tag(alloc_tag),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .res_valid(res_valid), .res_idx(res_idx), .res_addr(res_addr),
    .sdata_valid(sdata_valid), .sdata_idx(sdata_idx), .sdata_value(sdata_value),
    .retire_valid(retire_valid),
    .lrsp_valid(lrsp_valid), .lrsp_idx(lrsp_idx), .lrsp_kind(lrsp_kind),
    .lrsp_data(lrsp_data), .lrsp_tag(lrsp_tag),
    .flush_valid(flush_valid), .flush_idx(flush_idx)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Operation codes of the vector table
  localparam logic [2:0] OP_ALLOC = 3'd0, OP_RES = 3'd1, OP_SDAT = 3'd2, OP_RET = 3'd3, OP_RLS = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic        st;       // store flag for allocation
    logic [2:0]  idx;      // slot for resolve / data
    logic [2:0]  idx2;     // data slot for OP_RLS
    logic [15:0] addr;
    logic [31:0] data;     // tag for allocation, data otherwise
    logic        e_rsp;
    logic [1:0]  e_kind;   // 0 memory, 1 forwarded, 2 tag
    logic [31:0] e_val;    // alloc index, forwarded data or tag
    logic        e_fl;
    logic [2:0]  e_fidx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{OP_ALLOC,1'b1,3'd0,3'd0,16'h0000,32'd5,        1'b0,2'd0,32'd0,        1'b0,3'd0,4'd2},  // R2 store tag 5 -> slot 0
    '{OP_ALLOC,1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd1,        1'b0,3'd0,4'd2},  // R2 load -> slot 1
    '{OP_RES,  1'b0,3'd1,3'd0,16'h0010,32'd0,        1'b1,2'd0,32'd0,        1'b0,3'd0,4'd5},  // R5 older store address unknown
    '{OP_RES,  1'b0,3'd0,3'd0,16'h0010,32'd0,        1'b0,2'd0,32'd0,        1'b1,3'd1,4'd10}, // R10 late store hits load 1
    '{OP_ALLOC,1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd1,        1'b0,3'd0,4'd10}, // R10 tail rolled back to 1
    '{OP_RES,  1'b0,3'd1,3'd0,16'h0010,32'd0,        1'b1,2'd2,32'd5,        1'b0,3'd0,4'd7},  // R7 no data -> tag 5
    '{OP_SDAT, 1'b0,3'd0,3'd0,16'h0000,32'hAAAA0001, 1'b0,2'd0,32'd0,        1'b0,3'd0,4'd6},  // R6 store 0 data
    '{OP_ALLOC,1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd2,        1'b0,3'd0,4'd2},
    '{OP_RES,  1'b0,3'd2,3'd0,16'h0010,32'd0,        1'b1,2'd1,32'hAAAA0001, 1'b0,3'd0,4'd6},  // R6 forward
    '{OP_ALLOC,1'b1,3'd0,3'd0,16'h0000,32'd9,        1'b0,2'd0,32'd3,        1'b0,3'd0,4'd2},  // store tag 9 -> slot 3
    '{OP_RES,  1'b0,3'd3,3'd0,16'h0010,32'd0,        1'b0,2'd0,32'd0,        1'b0,3'd0,4'd11}, // R11 only older loads match
    '{OP_ALLOC,1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd4,        1'b0,3'd0,4'd2},
    '{OP_RES,  1'b0,3'd4,3'd0,16'h0010,32'd0,        1'b1,2'd2,32'd9,        1'b0,3'd0,4'd8},  // R8 youngest store 3
    '{OP_ALLOC,1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd5,        1'b0,3'd0,4'd2},
    '{OP_RLS,  1'b0,3'd5,3'd3,16'h0010,32'hBBBB0002, 1'b1,2'd1,32'hBBBB0002, 1'b0,3'd0,4'd9},  // R9 same-cycle data
    '{OP_ALLOC,1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd6,        1'b0,3'd0,4'd2},
    '{OP_RES,  1'b0,3'd6,3'd0,16'h0020,32'd0,        1'b1,2'd0,32'd0,        1'b0,3'd0,4'd5},  // R5 other address
    '{OP_RET,  1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd0,        1'b0,3'd0,4'd4},  // R4
    '{OP_RET,  1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd0,        1'b0,3'd0,4'd4},
    '{OP_ALLOC,1'b0,3'd0,3'd0,16'h0000,32'd0,        1'b0,2'd0,32'd7,        1'b0,3'd0,4'd2},
    '{OP_RES,  1'b0,3'd7,3'd0,16'h0010,32'd0,        1'b1,2'd1,32'hBBBB0002, 1'b0,3'd0,4'd8}   // R8 store 3 still youngest
  };

  task automatic idle_inputs();
    alloc_valid = 0; alloc_is_store = 0; alloc_tag = '0;
    res_valid = 0; res_idx = '0; res_addr = '0;
    sdata_valid = 0; sdata_idx = '0; sdata_value = '0;
    retire_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic alloc_one(input bit st, input logic [5:0] tag, input logic [2:0] exp_idx, input string req);
    @(negedge clk);
    chk(alloc_ready == 1'b1, req, 32'(alloc_ready), 32'd1);
    chk(alloc_idx == exp_idx, req, 32'(alloc_idx), 32'(exp_idx));
    alloc_valid = 1; alloc_is_store = st; alloc_tag = tag;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic run_row(input vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    @(negedge clk);
    case (v.op)
      OP_ALLOC: begin
        chk(alloc_ready == 1'b1, r, 32'(alloc_ready), 32'd1);
        chk(32'(alloc_idx) == v.e_val, r, 32'(alloc_idx), v.e_val);
        alloc_valid = 1; alloc_is_store = v.st; alloc_tag = v.data[5:0];
      end
      OP_RES:  begin res_valid = 1; res_idx = v.idx; res_addr = v.addr; end
      OP_SDAT: begin sdata_valid = 1; sdata_idx = v.idx; sdata_value = v.data; end
      OP_RET:  retire_valid = 1;
      OP_RLS:  begin
        res_valid = 1; res_idx = v.idx; res_addr = v.addr;
        sdata_valid = 1; sdata_idx = v.idx2; sdata_value = v.data;
      end
      default: ;
    endcase
    @(negedge clk);
    idle_inputs();
    chk(lrsp_valid == v.e_rsp, r, 32'(lrsp_valid), 32'(v.e_rsp));
    if (v.e_rsp) begin
      chk(lrsp_idx == v.idx, r, 32'(lrsp_idx), 32'(v.idx));
      chk(lrsp_kind == v.e_kind, r, 32'(lrsp_kind), 32'(v.e_kind));
      if (v.e_kind == 2'd1) chk(lrsp_data == v.e_val, r, lrsp_data, v.e_val);
      if (v.e_kind == 2'd2) chk(32'(lrsp_tag) == v.e_val, r, 32'(lrsp_tag), v.e_val);
    end
    chk(flush_valid == v.e_fl, r, 32'(flush_valid), 32'(v.e_fl));
    if (v.e_fl) chk(flush_idx == v.e_fidx, r, 32'(flush_idx), 32'(v.e_fidx));
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    do_reset();

    // R1: reset state
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R1", 32'(alloc_ready), 32'd1);
    chk(alloc_idx == 3'd0,   "R1", 32'(alloc_idx), 32'd0);
    chk(lrsp_valid == 1'b0,  "R1", 32'(lrsp_valid), 32'd0);
    chk(flush_valid == 1'b0, "R1", 32'(flush_valid), 32'd0);

    for (int i = 0; i < NV; i++) run_row(VEC[i]);

    // R2/R3: two more allocations wrap to slots 0 and 1, buffer becomes full
    alloc_one(1'b0, 6'd0, 3'd0, "R2");
    alloc_one(1'b0, 6'd0, 3'd1, "R2");
    @(negedge clk);
    chk(alloc_ready == 1'b0, "R3", 32'(alloc_ready), 32'd0);
    alloc_valid = 1;
    @(negedge clk);
    idle_inputs();
    chk(alloc_idx == 3'd2, "R3", 32'(alloc_idx), 32'd2);
    retire_valid = 1;
    @(negedge clk);
    idle_inputs();
    chk(alloc_ready == 1'b1, "R3", 32'(alloc_ready), 32'd1);
    alloc_one(1'b0, 6'd0, 3'd2, "R3");

    // R12: violation and allocation in the same cycle
    do_reset();
    alloc_one(1'b1, 6'd1, 3'd0, "R12");
    alloc_one(1'b0, 6'd0, 3'd1, "R12");
    @(negedge clk);
    res_valid = 1; res_idx = 3'd1; res_addr = 16'h0040;
    @(negedge clk);
    idle_inputs();
    chk(lrsp_valid && lrsp_kind == 2'd0, "R5", 32'(lrsp_kind), 32'd0);
    res_valid = 1; res_idx = 3'd0; res_addr = 16'h0040;
    alloc_valid = 1; alloc_is_store = 0;
    #1;
    chk(alloc_ready == 1'b0, "R12", 32'(alloc_ready), 32'd0);
    @(negedge clk);
    idle_inputs();
    chk(flush_valid == 1'b1 && flush_idx == 3'd1, "R10", 32'(flush_idx), 32'd1);
    alloc_one(1'b0, 6'd0, 3'd1, "R12");

    // R4: retire on empty buffer is ignored
    do_reset();
    @(negedge clk);
    retire_valid = 1;
    @(negedge clk);
    idle_inputs();
    alloc_one(1'b1, 6'd3, 3'd0, "R4");
    alloc_one(1'b0, 6'd0, 3'd1, "R4");
    @(negedge clk);
    res_valid = 1; res_idx = 3'd0; res_addr = 16'h0077;
    @(negedge clk);
    res_idx = 3'd1;
    @(negedge clk);
    idle_inputs();
    chk(lrsp_valid && lrsp_kind == 2'd2 && lrsp_tag == 6'd3, "R4", 32'(lrsp_tag), 32'd3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule